// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point operands and returns one product in the same format. Each word is a sign bit, a biased exponent field of `EXP_W` bits and a stored fraction of `FRAC_W` bits with a hidden leading one. The defaults of 8 and 23 give the common 32-bit single-precision format with bias 127. The exponent bias is always 2^(EXP_W-1)-1, and the block needs `EXP_W` >= 3 and `FRAC_W` >= 3.

An operand pair is presented with `in_valid` on any cycle, and a new pair may arrive every cycle. The first stage sorts each operand into a class, forms the sign and the exponent sum with the bias removed, and multiplies the two significands. The second stage normalizes the product by at most one place and rounds it to nearest, ties to even, using a guard bit, a round bit and a sticky bit. It normalizes again if rounding carries out. It then picks the special result or the finite result and sets the overflow and underflow flags.

Denormal operands count as zero. A result too small for the normal range is flushed to a signed zero. The only rounding mode is round to nearest even.

Top module: `fpm_mul`

## Requirements
- R1: Each pair accepted with `in_valid` high at a rising edge gives `out_valid` high after exactly the second rising edge that follows. `out_valid` is high for exactly one cycle per pair, so the block accepts one pair per cycle.
- R2: For finite nonzero operands, the result sign is the XOR of the operand signs, and the unrounded biased exponent is ea + eb - bias. The exponent is one higher when the significand product is at least 2, in which case the product is shifted right one place. An exactly representable product is returned unchanged.
- R3: A product that cannot be represented exactly is rounded to the nearest representable value. On an exact tie it goes to the candidate whose lowest fraction bit is 0.
- R4: When rounding carries out of the significand (all ones plus one), the fraction becomes all zeros and the exponent goes up by one.
- R5: If either operand is a NaN (exponent field all ones, fraction nonzero), or an infinity meets a zero, the result is the quiet NaN: sign 0, exponent all ones, fraction MSB 1 and the rest 0 (0x7FC00000 at the defaults). Both flags are 0.
- R6: An infinity (exponent all ones, fraction 0) times a finite nonzero operand gives an infinity whose sign is the XOR of the operand signs. Both flags are 0.
- R7: An operand whose exponent field is 0 counts as zero, whatever its fraction. When the other operand is finite, the result is a zero whose sign is the XOR of the operand signs, and both flags are 0.
- R8: If the biased exponent after rounding and renormalization is all ones or larger, the result is a signed infinity and `out_ovf` is 1.
- R9: If the biased exponent after rounding and renormalization is 0 or less, the result is a signed zero and `out_unf` is 1.
- R10: While `rst_n` is low, and for the cycles after its release until a pair is accepted, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | EXP_W+FRAC_W+1 | First operand |
| in_b | input | EXP_W+FRAC_W+1 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | EXP_W+FRAC_W+1 | Product |
| out_ovf | output | 1 | Overflow flag for this result |
| out_unf | output | 1 | Underflow flag for this result |

## Verification
An instance with a 4-bit exponent and a 3-bit fraction is driven with every one of the 65,536 operand pairs, one pair per cycle. The expected value comes from exact integer arithmetic: the bench finds the leading bit of the product, compares the discarded remainder with half a unit, and applies the range limits. This separates exact products, inexact products that round down, inexact products that round up, ties, carry-out renormalization, overflow, underflow and every special-operand pairing. A default-width instance is then given single, isolated pairs. These pin the 32-bit constants (tie cases in both directions, the quiet NaN code, signed infinities, flushed denormals and both range limits) and show that the output is valid on exactly the second cycle.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  // Class of a multiply once both operands are known.
  typedef enum logic [1:0] {
    KIND_NUM  = 2'd0,
    KIND_ZERO = 2'd1,
    KIND_INF  = 2'd2,
    KIND_NAN  = 2'd3
  } fpm_kind_e;
endpackage

// File: rtl/fpm_rst_sync.sv
`timescale 1ns/1ps
module fpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       sig,
  output logic                  is_zero,
  output logic                  is_inf,
  output logic                  is_nan
);
  logic [FRAC_W-1:0] frac;
  logic              exp_min;
  logic              exp_max;
  logic              frac_nz;

  always_comb begin
    sign    = op[EXP_W+FRAC_W];
    exp_f   = op[EXP_W+FRAC_W-1:FRAC_W];
    frac    = op[FRAC_W-1:0];
    exp_min = (exp_f == '0);
    exp_max = &exp_f;
    frac_nz = |frac;
    // exponent field 0: zero or denormal, both handled as zero
    is_zero = exp_min;
    is_inf  = exp_max && !frac_nz;
    is_nan  = exp_max && frac_nz;
    sig     = {!exp_min, frac};
  end
endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
module fpm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [2*FRAC_W+1:0]      prod,
  input  logic signed [EXP_W+1:0]  exp_in,
  output logic [FRAC_W-1:0]        frac_out,
  output logic signed [EXP_W+1:0]  exp_out
);
  localparam int PROD_W = 2*FRAC_W + 2;
  localparam int EXP_X  = EXP_W + 2;
  localparam int MANT_W = FRAC_W + 1;

  logic              top_set;
  logic [MANT_W-1:0] mant_pre;
  logic              guard_b;
  logic              round_b;
  logic              sticky_b;
  logic              bump;
  logic [MANT_W:0]   mant_sum;
  logic              carry;

  always_comb begin
    top_set = prod[PROD_W-1];
    if (top_set) begin
      mant_pre = prod[PROD_W-1:FRAC_W+1];
      guard_b  = prod[FRAC_W];
      round_b  = prod[FRAC_W-1];
      sticky_b = |prod[FRAC_W-2:0];
    end else begin
      mant_pre = prod[PROD_W-2:FRAC_W];
      guard_b  = prod[FRAC_W-1];
      round_b  = prod[FRAC_W-2];
      sticky_b = |prod[FRAC_W-3:0];
    end
    // nearest, ties to even
    bump     = guard_b && (round_b || sticky_b || mant_pre[0]);
    mant_sum = {1'b0, mant_pre} + {{MANT_W{1'b0}}, bump};
    carry    = mant_sum[MANT_W];
    frac_out = carry ? '0 : mant_sum[FRAC_W-1:0];
    exp_out  = exp_in + EXP_X'(top_set) + EXP_X'(carry);
  end
endmodule

// File: rtl/fpm_mul.sv
`timescale 1ns/1ps
module fpm_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] in_a,
  input  logic [EXP_W+FRAC_W:0] in_b,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_result,
  output logic                  out_ovf,
  output logic                  out_unf
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXP_X  = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam int N_OPS  = 2;
  localparam logic signed [EXP_X-1:0] BIAS_X = EXP_X'(BIAS);
  localparam logic signed [EXP_X-1:0] EMAX_X = EXP_X'(EMAX);
  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] QNAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};

  logic rst_sync_n;

  fpm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // ---------------- operand decode ----------------
  logic [WORD_W-1:0] op_w   [N_OPS];
  logic              sgn_w  [N_OPS];
  logic [EXP_W-1:0]  exp_w  [N_OPS];
  logic [SIG_W-1:0]  sig_w  [N_OPS];
  logic              zero_w [N_OPS];
  logic              inf_w  [N_OPS];
  logic              nan_w  [N_OPS];

  assign op_w[0] = in_a;
  assign op_w[1] = in_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .op      (op_w[g]),
      .sign    (sgn_w[g]),
      .exp_f   (exp_w[g]),
      .sig     (sig_w[g]),
      .is_zero (zero_w[g]),
      .is_inf  (inf_w[g]),
      .is_nan  (nan_w[g])
    );
  end

  // ---------------- stage 1: classify, exponent sum, product ----------------
  logic                    s1_d_sign;
  fpm_kind_e               s1_d_kind;
  logic signed [EXP_X-1:0] s1_d_exp;
  logic [PROD_W-1:0]       s1_d_prod;

  logic                    v1_q;
  logic                    s1_q_sign;
  fpm_kind_e               s1_q_kind;
  logic signed [EXP_X-1:0] s1_q_exp;
  logic [PROD_W-1:0]       s1_q_prod;

  always_comb begin
    s1_d_sign = sgn_w[0] ^ sgn_w[1];
    if (nan_w[0] || nan_w[1] || (inf_w[0] && zero_w[1]) || (inf_w[1] && zero_w[0])) begin
      s1_d_kind = KIND_NAN;
    end else if (inf_w[0] || inf_w[1]) begin
      s1_d_kind = KIND_INF;
    end else if (zero_w[0] || zero_w[1]) begin
      s1_d_kind = KIND_ZERO;
    end else begin
      s1_d_kind = KIND_NUM;
    end
    s1_d_exp  = EXP_X'(exp_w[0]) + EXP_X'(exp_w[1]) - BIAS_X;
    s1_d_prod = PROD_W'(sig_w[0]) * PROD_W'(sig_w[1]);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_q_sign <= s1_d_sign;
      s1_q_kind <= s1_d_kind;
      s1_q_exp  <= s1_d_exp;
      s1_q_prod <= s1_d_prod;
    end
  end

  // ---------------- stage 2: normalize, round, select ----------------
  logic [FRAC_W-1:0]       rnd_frac;
  logic signed [EXP_X-1:0] rnd_exp;

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .prod     (s1_q_prod),
    .exp_in   (s1_q_exp),
    .frac_out (rnd_frac),
    .exp_out  (rnd_exp)
  );

  logic [WORD_W-1:0] res_d;
  logic              ovf_d;
  logic              unf_d;

  always_comb begin
    ovf_d = 1'b0;
    unf_d = 1'b0;
    unique case (s1_q_kind)
      KIND_NAN:  res_d = QNAN_WORD;
      KIND_INF:  res_d = {s1_q_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      KIND_ZERO: res_d = {s1_q_sign, {(WORD_W-1){1'b0}}};
      default: begin
        if (rnd_exp >= EMAX_X) begin
          res_d = {s1_q_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf_d = 1'b1;
        end else if (rnd_exp <= 0) begin
          res_d = {s1_q_sign, {(WORD_W-1){1'b0}}};
          unf_d = 1'b1;
        end else begin
          res_d = {s1_q_sign, rnd_exp[EXP_W-1:0], rnd_frac};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (v1_q) begin
      out_result <= res_d;
      out_ovf    <= ovf_d;
      out_unf    <= unf_d;
    end
  end

  // ---------------- assertions ----------------
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> ##2 out_valid); // R1

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !(&out_result[WORD_W-2:FRAC_W] && |out_result[FRAC_W-1:0]))
    |-> (out_result[WORD_W-1] == ($past(in_a[WORD_W-1], 2) ^ $past(in_b[WORD_W-1], 2)))); // R2

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && &out_result[WORD_W-2:FRAC_W] && |out_result[FRAC_W-1:0])
    |-> (out_result[FRAC_W-1:0] == QNAN_FRAC && !out_result[WORD_W-1] && !out_ovf && !out_unf)); // R5

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> !(out_ovf && out_unf)); // R8

  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ovf)
    |-> (&out_result[WORD_W-2:FRAC_W] && out_result[FRAC_W-1:0] == '0)); // R8

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_unf) |-> (out_result[WORD_W-2:0] == '0)); // R9
endmodule

// File: tb/fpm_mul_tb_top.sv
`timescale 1ns/1ps
module fpm_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  int   n_run  = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  // small format: 4-bit exponent, 3-bit fraction, bias 7
  logic       s_v;
  logic [7:0] s_a, s_b;
  logic       s_ov_valid;
  logic [7:0] s_r;
  logic       s_ovf, s_unf;

  fpm_mul #(.EXP_W(4), .FRAC_W(3)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (s_v),
    .in_a       (s_a),
    .in_b       (s_b),
    .out_valid  (s_ov_valid),
    .out_result (s_r),
    .out_ovf    (s_ovf),
    .out_unf    (s_unf)
  );

  // default single-precision width
  logic        w_v;
  logic [31:0] w_a, w_b;
  logic        w_ov_valid;
  logic [31:0] w_r;
  logic        w_ovf, w_unf;

  fpm_mul dut_wide_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (w_v),
    .in_a       (w_a),
    .in_b       (w_b),
    .out_valid  (w_ov_valid),
    .out_result (w_r),
    .out_ovf    (w_ovf),
    .out_unf    (w_unf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Exact integer model of the small format.
  function automatic void ref_small(input logic [7:0] a, input logic [7:0] b,
                                    output logic [7:0] r, output logic ov,
                                    output logic un, output int req);
    int ea, eb, fa, fb, p, k, sh, q, rem, half, e;
    logic s;
    ea = int'(a[6:3]); eb = int'(b[6:3]);
    fa = int'(a[2:0]); fb = int'(b[2:0]);
    s  = a[7] ^ b[7];
    ov = 1'b0; un = 1'b0;
    if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0) ||
        (ea == 15 && eb == 0) || (eb == 15 && ea == 0)) begin
      r = 8'h7C; req = 5;                       // R5 quiet NaN
    end else if (ea == 15 || eb == 15) begin
      r = {s, 7'h78}; req = 6;                  // R6 signed infinity
    end else if (ea == 0 || eb == 0) begin
      r = {s, 7'h00}; req = 7;                  // R7 signed zero
    end else begin
      p    = (8 + fa) * (8 + fb);
      k    = (p >= 128) ? 7 : 6;
      sh   = k - 3;
      q    = p >> sh;
      rem  = p - (q << sh);
      half = 1 << (sh - 1);
      req  = 2;                                 // R2 exact / rounds down
      if (rem > half || (rem == half && (q % 2) == 1)) begin
        q   = q + 1;
        req = 3;                                // R3 rounds up
      end
      if (q == 16) begin
        q   = 8;
        k   = k + 1;
        req = 4;                                // R4 carry-out renormalized
      end
      e = ea + eb - 7 + (k - 6);
      if (e >= 15) begin
        r = {s, 7'h78}; ov = 1'b1; req = 8;     // R8 overflow
      end else if (e <= 0) begin
        r = {s, 7'h00}; un = 1'b1; req = 9;     // R9 underflow
      end else begin
        r = {s, e[3:0], q[2:0]};
      end
    end
  endfunction

  task automatic run_wide(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] er, input logic eo, input logic eu,
                          input string req);
    @(negedge clk);
    w_a = a; w_b = b; w_v = 1'b1;
    @(negedge clk);
    w_v = 1'b0;
    chk(w_ov_valid == 1'b0, "R1", "valid one cycle early", 64'(w_ov_valid), 64'd0);
    @(negedge clk);
    chk(w_ov_valid && w_r == er && w_ovf == eo && w_unf == eu, req,
        $sformatf("%08h*%08h", a, b),
        64'({w_ov_valid, w_ovf, w_unf, w_r}), 64'({1'b1, eo, eu, er}));
  endtask

  initial begin
    logic [7:0] er;
    logic       eo, eu;
    int         req;
    logic [7:0] pa, pb;
    rst_n = 1'b0;
    s_v = 1'b0; s_a = '0; s_b = '0;
    w_v = 1'b0; w_a = '0; w_b = '0;
    repeat (3) @(negedge clk);
    chk(!s_ov_valid && !w_ov_valid, "R10", "valid during reset",
        64'({s_ov_valid, w_ov_valid}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!s_ov_valid && !w_ov_valid, "R10", "valid after release",
        64'({s_ov_valid, w_ov_valid}), 64'd0);

    // Wide directed cases
    run_wide(32'h3FC00000, 32'h40000000, 32'h40400000, 1'b0, 1'b0, "R2");
    run_wide(32'hC0400000, 32'h3F000000, 32'hBFC00000, 1'b0, 1'b0, "R2");
    run_wide(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0, 1'b0, "R3");
    run_wide(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 1'b0, 1'b0, "R3");
    run_wide(32'h7F800000, 32'h00000000, 32'h7FC00000, 1'b0, 1'b0, "R5");
    run_wide(32'h7F800001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0, "R5");
    run_wide(32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b0, 1'b0, "R6");
    run_wide(32'h00000001, 32'h3F800000, 32'h00000000, 1'b0, 1'b0, "R7");
    run_wide(32'h80000001, 32'h3F800000, 32'h80000000, 1'b0, 1'b0, "R7");
    run_wide(32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, "R8");
    run_wide(32'hFF000000, 32'h40000000, 32'hFF800000, 1'b1, 1'b0, "R8");
    run_wide(32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1, "R9");
    run_wide(32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1, "R9");
    @(negedge clk);
    chk(w_ov_valid == 1'b0, "R1", "valid held too long", 64'(w_ov_valid), 64'd0);

    // Small format: every pair, one per cycle (R1 throughput, R2..R9 values)
    for (int i = 0; i < 65536 + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        pa = 8'((i - 2) >> 8);
        pb = 8'((i - 2) & 255);
        ref_small(pa, pb, er, eo, eu, req);
        chk(s_ov_valid && s_r == er && s_ovf == eo && s_unf == eu,
            $sformatf("R%0d", req), $sformatf("small %02h*%02h", pa, pb),
            64'({s_ov_valid, s_ovf, s_unf, s_r}), 64'({1'b1, eo, eu, er}));
      end
      if (i < 65536) begin
        s_a = 8'(i >> 8);
        s_b = 8'(i & 255);
        s_v = 1'b1;
      end else begin
        s_v = 1'b0;
      end
    end
    @(negedge clk);
    chk(s_ov_valid == 1'b0, "R1", "small valid after stream", 64'(s_ov_valid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule